// File: doc/BRIEF.md
# Three-Byte Command Frame Assembler

This block sits on the read side of a byte-wide receive queue, for example the one behind a UART receiver. Whenever the queue reports a waiting byte, the block takes it, sends a one-cycle read acknowledge back to the queue, and shifts the byte into the low end of a 24-bit holding register. The bytes already held move up by one byte position.

Every group of three accepted bytes forms one command frame. The frame is sliced into two fields:

- A 12-bit memory address, made from the low nibble of the first byte followed by the whole second byte.
- A 7-bit character value, made from the low seven bits of the third byte.

Both fields are registered. They drive a downstream memory together with a single-cycle write strobe. The upper nibble of the first byte and the top bit of the third byte have no effect on any output.

Acceptance is gated by the block's own acknowledge. A byte can be taken only when the acknowledge was low in the previous cycle. This gives the queue one clock to retire its flag, so no byte is ever consumed twice.

Top module: `cmd_frame_assembler`

## Requirements
- R1: Synchronous reset (`rst` high at a rising edge) clears the read acknowledge, the write strobe, the address and the character outputs to zero, and restarts frame counting at the first byte.
- R2: A byte is accepted at a rising edge exactly when `rx_present` is high and `rx_ack` is low. `rx_ack` is then high for exactly the following cycle. If `rx_present` stays high without a break, a byte is accepted every second cycle.
- R3: `rx_ack` stays low in every cycle that follows an edge where no byte was accepted, including every edge where `rx_present` is low.
- R4: Accepted bytes enter the holding register at its least significant byte, and older bytes move up by eight bits. The first byte of a frame therefore ends in bits 23..16, the second in bits 15..8 and the third in bits 7..0.
- R5: On frame completion, `wr_addr` takes register bits 19..8, which is `{first[3:0], second[7:0]}`.
- R6: On frame completion, `wr_char` takes register bits 6..0, which is `third[6:0]`. Bit 7 of the third byte is discarded.
- R7: `wr_en` is high for exactly one cycle per frame. It rises on the edge after the one that accepted the third byte, and `wr_addr` and `wr_char` already carry the new frame in that cycle.
- R8: `wr_en` stays low while the first and second bytes of a frame are being collected.
- R9: `wr_addr` and `wr_char` hold their values in every cycle in which `wr_en` is low, until the next frame completes.
- R10: Bits 7..4 of the first byte of a frame have no effect on `wr_addr` or `wr_char`.
- R11: A reset in the middle of a frame discards the partial frame. The next three accepted bytes form a complete frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_data | input | 8 | Byte offered by the receive queue |
| rx_present | input | 1 | Receive queue holds a byte |
| rx_ack | output | 1 | One-cycle pulse: the offered byte was taken |
| wr_addr | output | 12 | Address field of the last complete frame |
| wr_char | output | 7 | Character field of the last complete frame |
| wr_en | output | 1 | One-cycle write strobe per completed frame |

## Verification
The bench holds `rx_present` high across several cycles. A design without the acknowledge gate would take one byte several times, close the frame early and pulse `wr_en` too often.

It sends two frames that differ only in the upper nibble of the first byte. A design that slices the wrong bits, or that lets the top of the register leak into the address, would give different addresses for the two frames.

It also sets bit 7 of the third byte, to catch a character field that is one bit too wide. It resets in the middle of a frame, to catch a byte counter that survives reset, since such a design would complete the next frame one byte early.

Finally, it watches that the fields hold between frames and that the strobe falls after one cycle. This exposes designs that update the outputs on every byte or stretch the write pulse.

// File: rtl/cfa_pkg.sv
package cfa_pkg;
    localparam int unsigned DEF_BYTE_W      = 8;
    localparam int unsigned DEF_FRAME_BYTES = 3;
    localparam int unsigned DEF_ADDR_LSB    = 8;
    localparam int unsigned DEF_ADDR_W      = 12;
    localparam int unsigned DEF_CHAR_W      = 7;
endpackage

// File: rtl/cfa_rx_handshake.sv
module cfa_rx_handshake (
    input  logic clk,
    input  logic rst,
    input  logic present,
    output logic take,
    output logic ack
);
    typedef struct packed {
        logic ack;
    } hs_t;

    hs_t hs_d, hs_q;

    always_comb begin
        // a byte may be taken only if no acknowledge went out last cycle
        take      = present & ~hs_q.ack;
        hs_d      = hs_q;
        hs_d.ack  = take;
    end

    always_ff @(posedge clk) begin
        if (rst) hs_q <= '0;
        else     hs_q <= hs_d;
    end

    assign ack = hs_q.ack;
endmodule

// File: rtl/cfa_frame_shifter.sv
module cfa_frame_shifter #(
    parameter int unsigned BYTE_W      = cfa_pkg::DEF_BYTE_W,
    parameter int unsigned FRAME_BYTES = cfa_pkg::DEF_FRAME_BYTES,
    parameter int unsigned ADDR_LSB    = cfa_pkg::DEF_ADDR_LSB,
    parameter int unsigned ADDR_W      = cfa_pkg::DEF_ADDR_W,
    parameter int unsigned CHAR_W      = cfa_pkg::DEF_CHAR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic [BYTE_W-1:0] din,
    output logic [ADDR_W-1:0] addr_field,
    output logic [CHAR_W-1:0] char_field,
    output logic              frame_done
);
    localparam int unsigned SHIFT_W = BYTE_W * FRAME_BYTES;
    localparam int unsigned CNT_W   = (FRAME_BYTES > 1) ? $clog2(FRAME_BYTES) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_BYTES - 1);

    typedef struct packed {
        logic [SHIFT_W-1:0] sreg;
        logic [CNT_W-1:0]   cnt;
        logic               done;
    } sh_t;

    sh_t sh_d, sh_q;

    always_comb begin
        sh_d      = sh_q;
        sh_d.done = 1'b0;
        if (take) begin
            sh_d.sreg = (sh_q.sreg << BYTE_W) | SHIFT_W'(din);
            if (sh_q.cnt == LAST_IDX) begin
                sh_d.cnt  = '0;
                sh_d.done = 1'b1;
            end else begin
                sh_d.cnt = sh_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= sh_d;
    end

    assign addr_field = sh_q.sreg[ADDR_LSB +: ADDR_W];
    assign char_field = sh_q.sreg[CHAR_W-1:0];
    assign frame_done = sh_q.done;
endmodule

// File: rtl/cfa_field_latch.sv
module cfa_field_latch #(
    parameter int unsigned ADDR_W = cfa_pkg::DEF_ADDR_W,
    parameter int unsigned CHAR_W = cfa_pkg::DEF_CHAR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_done,
    input  logic [ADDR_W-1:0] addr_field,
    input  logic [CHAR_W-1:0] char_field,
    output logic [ADDR_W-1:0] addr,
    output logic [CHAR_W-1:0] chr,
    output logic              wen
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [CHAR_W-1:0] chr;
        logic              wen;
    } fl_t;

    fl_t fl_d, fl_q;

    always_comb begin
        fl_d     = fl_q;
        fl_d.wen = frame_done;
        if (frame_done) begin
            fl_d.addr = addr_field;
            fl_d.chr  = char_field;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) fl_q <= '0;
        else     fl_q <= fl_d;
    end

    assign addr = fl_q.addr;
    assign chr  = fl_q.chr;
    assign wen  = fl_q.wen;
endmodule

// File: rtl/cmd_frame_assembler.sv
module cmd_frame_assembler #(
    parameter int unsigned BYTE_W      = cfa_pkg::DEF_BYTE_W,
    parameter int unsigned FRAME_BYTES = cfa_pkg::DEF_FRAME_BYTES,
    parameter int unsigned ADDR_LSB    = cfa_pkg::DEF_ADDR_LSB,
    parameter int unsigned ADDR_W      = cfa_pkg::DEF_ADDR_W,
    parameter int unsigned CHAR_W      = cfa_pkg::DEF_CHAR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              rx_present,
    output logic              rx_ack,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [CHAR_W-1:0] wr_char,
    output logic              wr_en
);
    logic              take;
    logic              frame_done;
    logic [ADDR_W-1:0] addr_field;
    logic [CHAR_W-1:0] char_field;

    cfa_rx_handshake u_hs (
        .clk     (clk),
        .rst     (rst),
        .present (rx_present),
        .take    (take),
        .ack     (rx_ack)
    );

    cfa_frame_shifter #(
        .BYTE_W      (BYTE_W),
        .FRAME_BYTES (FRAME_BYTES),
        .ADDR_LSB    (ADDR_LSB),
        .ADDR_W      (ADDR_W),
        .CHAR_W      (CHAR_W)
    ) u_shift (
        .clk        (clk),
        .rst        (rst),
        .take       (take),
        .din        (rx_data),
        .addr_field (addr_field),
        .char_field (char_field),
        .frame_done (frame_done)
    );

    cfa_field_latch #(
        .ADDR_W (ADDR_W),
        .CHAR_W (CHAR_W)
    ) u_fields (
        .clk        (clk),
        .rst        (rst),
        .frame_done (frame_done),
        .addr_field (addr_field),
        .char_field (char_field),
        .addr       (wr_addr),
        .chr        (wr_char),
        .wen        (wr_en)
    );
endmodule

// File: rtl/cfa_checker.sv
module cfa_checker #(
    parameter int unsigned FRAME_BYTES = cfa_pkg::DEF_FRAME_BYTES,
    parameter int unsigned ADDR_W      = cfa_pkg::DEF_ADDR_W,
    parameter int unsigned CHAR_W      = cfa_pkg::DEF_CHAR_W
) (
    input logic              clk,
    input logic              rst,
    input logic              rx_present,
    input logic              rx_ack,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [CHAR_W-1:0] wr_char
);
    int unsigned acks_seen_q;

    always_ff @(posedge clk) begin
        if (rst) acks_seen_q <= 0;
        else if (rx_ack) acks_seen_q <= (acks_seen_q == FRAME_BYTES - 1) ? 0 : acks_seen_q + 1;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!rx_ack && !wr_en && wr_addr == '0 && wr_char == '0));

    // R2
    ack_single_chk: assert property (@(posedge clk) disable iff (rst)
        rx_ack |=> !rx_ack);

    // R3
    ack_needs_present_chk: assert property (@(posedge clk) disable iff (rst)
        rx_ack |-> $past(rx_present));

    // R7
    wen_single_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en);

    // R8
    wen_after_frame_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (acks_seen_q == 0 && $past(rx_ack)));

    // R9
    fields_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |-> ($stable(wr_addr) && $stable(wr_char)));
endmodule

bind cmd_frame_assembler cfa_checker #(
    .FRAME_BYTES (FRAME_BYTES),
    .ADDR_W      (ADDR_W),
    .CHAR_W      (CHAR_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .rx_present (rx_present),
    .rx_ack     (rx_ack),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_char    (wr_char)
);

// File: tb/sim_cmd_frame_assembler.sv
`timescale 1ns/1ps
module sim_cmd_frame_assembler;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  rx_data = '0;
    logic        rx_present = 1'b0;
    logic        rx_ack;
    logic [11:0] wr_addr;
    logic [6:0]  wr_char;
    logic        wr_en;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    cmd_frame_assembler u0 (
        .clk        (clk),
        .rst        (rst),
        .rx_data    (rx_data),
        .rx_present (rx_present),
        .rx_ack     (rx_ack),
        .wr_addr    (wr_addr),
        .wr_char    (wr_char),
        .wr_en      (wr_en)
    );

    // {first, second, third, expected address, expected character}
    localparam logic [43:0] VEC [0:5] = '{
        {8'h12, 8'h34, 8'h56, 12'h234, 8'h56},
        {8'hFF, 8'hFF, 8'hFF, 12'hFFF, 8'h7F},
        {8'h00, 8'h00, 8'h80, 12'h000, 8'h00},
        {8'hA5, 8'h5A, 8'hC3, 12'h55A, 8'h43},
        {8'h3C, 8'h0F, 8'h7E, 12'hC0F, 8'h7E},
        {8'hF1, 8'h00, 8'h01, 12'h100, 8'h01}
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // one byte offered for one cycle, then one idle cycle
    task automatic send_byte(input logic [7:0] b, input bit last);
        @(negedge clk);
        rx_present = 1'b1;
        rx_data    = b;
        @(negedge clk);
        check(rx_ack == 1'b1, "R2 ack after accept", rx_ack, 1);
        check(wr_en == 1'b0, "R8 no strobe while collecting", wr_en, 0);
        rx_present = 1'b0;
        @(negedge clk);
        check(rx_ack == 1'b0, "R3 ack low when idle", rx_ack, 0);
        check(wr_en == last, "R7 strobe after third byte", wr_en, last);
    endtask

    task automatic send_frame(input logic [7:0] b0, b1, b2, input logic [11:0] ea, input logic [6:0] ec, input string tag);
        send_byte(b0, 1'b0);
        send_byte(b1, 1'b0);
        send_byte(b2, 1'b1);
        check(wr_addr == ea, {tag, " address"}, wr_addr, ea);
        check(wr_char == ec, {tag, " character"}, wr_char, ec);
        @(negedge clk);
        check(wr_en == 1'b0, "R7 strobe one cycle", wr_en, 0);
        check(wr_addr == ea && wr_char == ec, "R9 fields hold", {wr_addr, wr_char}, {ea, ec});
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(rx_ack == 0 && wr_en == 0 && wr_addr == 0 && wr_char == 0, "R1 reset state",
              {rx_ack, wr_en, wr_addr, wr_char}, 0);
        rst = 1'b0;

        // R4 R5 R6 table-driven frames
        for (int i = 0; i < 6; i++) begin
            send_frame(VEC[i][43:36], VEC[i][35:28], VEC[i][27:20], VEC[i][19:8], VEC[i][6:0], "R4 R5 R6 frame");
        end

        // R10 upper nibble of first byte ignored
        send_frame(8'h07, 8'h22, 8'h11, 12'h722, 7'h11, "R10 nibble clear");
        send_frame(8'hF7, 8'h22, 8'h11, 12'h722, 7'h11, "R10 nibble set");

        // R9 idle gap keeps fields
        repeat (5) @(negedge clk);
        check(wr_addr == 12'h722 && wr_char == 7'h11 && wr_en == 0, "R9 hold over idle", {wr_addr, wr_char}, {12'h722, 7'h11});

        // R2 continuous present: bytes every other cycle
        begin
            int acks = 0;
            int wens = 0;
            @(negedge clk);
            rx_present = 1'b1;
            rx_data    = 8'h9A;
            for (int k = 0; k < 6; k++) begin
                @(negedge clk);
                if (rx_ack) acks++;
                if (wr_en) wens++;
            end
            rx_present = 1'b0;
            check(acks == 3, "R2 one accept per two cycles", acks, 3);
            check(wens == 1, "R7 single strobe", wens, 1);
            check(wr_addr == 12'hA9A, "R5 address from held present", wr_addr, 12'hA9A);
            check(wr_char == 7'h1A, "R6 character from held present", wr_char, 7'h1A);
        end

        // R11 reset mid-frame
        send_byte(8'h55, 1'b0);
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check(wr_addr == 0 && wr_char == 0 && wr_en == 0 && rx_ack == 0, "R1 reset after use",
              {wr_addr, wr_char}, 0);
        rst = 1'b0;
        send_frame(8'h01, 8'h23, 8'h45, 12'h123, 7'h45, "R11 frame after reset");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule